// File: doc/BRIEF.md
# Moving-Target Test Video Generator

This block produces a parallel grayscale video stream used to exercise an image-processing pipeline. It runs entirely from one reference clock and emits one 8-bit pixel per clock, together with an active-high frame sync, an active-high line sync and a data-valid flag. Every frame shows a square target of programmable size and gray level. The target is drawn over a background that is either a single programmed gray level or an image streamed in pixel by pixel from an external frame-store reader.

An external controller writes the run-time settings through a simple write-only register port. These settings are the two gray levels, the target size, the horizontal speed, the target row, the active pixel count per line and the background source. All writes land in shadow registers and take effect together at the start of the next frame. The target moves sideways once per frame by the speed value and turns around at the edges of the active area. The sync periods are parameters. At the default 50 MHz rate they give a 33 ms / 1.2 ms frame and a 35 µs / 8.4 µs line.

Top module: `vidgen_top`

## Requirements
- R1: After reset, `vid_fsync` is low for FRAME_LO cycles and then high for FRAME_HI cycles, repeating without gaps.
- R2: `vid_lsync` is low whenever `vid_fsync` is low. From the first cycle of each frame-high period it alternates LINE_HI cycles high and LINE_LO cycles low. The row index counts the line-high periods of the frame from 0.
- R3: `vid_valid` is high only during line-high cycles whose column (the cycle index within the line, from 0) is below the programmed active limit. Whenever `vid_valid` is low, `vid_pix` carries the programmed background gray.
- R4: A valid pixel is a target pixel when x ≤ column < x + size and ypos ≤ row < ypos + size. It then carries the target gray in both background modes.
- R5: Register addresses are: 0 target gray (data bits 7:0), 1 background gray (bits 7:0), 2 size, 3 speed, 4 target row ypos, 5 active limit (all 12-bit), and 6 background source (bit 0; 1 = streamed). Address 7 is ignored. A write changes the output only from the next rising edge of the frame sync onward, never within the current frame.
- R6: On every frame start, x moves as follows. Moving forward, x becomes x + speed, unless x + speed + size would exceed the limit. In that case x becomes limit − size (or 0 if size > limit) and the direction turns backward. Moving backward, x becomes x − speed, unless x < speed. In that case x becomes 0 and the direction turns forward. After reset x = 0 and the direction is forward.
- R7: When the streamed background is selected, `bg_req` is high exactly two cycles before each valid pixel. `bg_valid`/`bg_pix` are sampled in the cycle between. A non-target valid pixel then carries the streamed value.
- R8: If `bg_valid` is low in a cycle where a requested pixel is sampled, that pixel falls back to the programmed background gray. `underflow` also goes high in the cycle that pixel appears and stays high until reset.
- R9: During and right after reset, all outputs are 0. The registers then hold target gray 255, background gray 0, size 16, speed 1, ypos 0, limit LINE_HI and the constant background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one pixel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Register write data |
| bg_req | output | 1 | Request for one streamed background pixel |
| bg_valid | input | 1 | Streamed background pixel present |
| bg_pix | input | 8 | Streamed background pixel value |
| vid_fsync | output | 1 | Frame sync, active high |
| vid_lsync | output | 1 | Line sync, active high |
| vid_valid | output | 1 | Pixel data valid |
| vid_pix | output | 8 | Grayscale pixel |
| underflow | output | 1 | Sticky flag: a streamed pixel arrived late |

## Verification
The hardest case to reach is the target bouncing off the right edge while a gray-level write lands in the middle of a frame. The wall contact depends on many frames of accumulated motion, and the write has to fall strictly between two frame starts. The bench shrinks the timing parameters so that a frame lasts a few hundred cycles. It sets a speed that does not divide the free width, so the clamp-to-edge path is taken, and it times its mid-frame write from the observed rise of the frame sync. The streamed mode is driven by a responder that answers each request one cycle later, and in a second phase it drops every eighth answer to provoke the fallback.

// File: rtl/vg_pkg.sv
// Package: shared constants, register address codes and the settings record
// for the moving-target video generator. Assumes coordinates fit in VG_CW bits.
package vg_pkg;

    localparam int unsigned VG_CW = 12;   // coordinate / register data width
    localparam int unsigned VG_GW = 8;    // gray level width
    localparam int unsigned VG_AW = 3;    // register address width

    typedef enum logic [VG_AW-1:0] {
        REG_TGT_GRAY = 3'd0,
        REG_BG_GRAY  = 3'd1,
        REG_SIZE     = 3'd2,
        REG_SPEED    = 3'd3,
        REG_YPOS     = 3'd4,
        REG_LIMIT    = 3'd5,
        REG_SRC      = 3'd6
    } vg_reg_e;

    typedef struct packed {
        logic [VG_GW-1:0] tgt_gray;
        logic [VG_GW-1:0] bg_gray;
        logic [VG_CW-1:0] size;
        logic [VG_CW-1:0] speed;
        logic [VG_CW-1:0] ypos;
        logic [VG_CW-1:0] limit;
        logic             stream_bg;
    } vg_cfg_t;

endpackage

// File: rtl/vg_timing.sv
// Module: frame and line timing counters.
// Produces frame-high, line-high, the column and row of the current cycle and
// a one-cycle frame_start pulse in the last frame-low cycle. Assumes
// FRAME_LO >= 1, LINE_HI < 2**VG_CW and fewer than 2**VG_CW lines per frame.
module vg_timing
    import vg_pkg::*;
#(
    parameter int unsigned FRAME_HI = 1650000,
    parameter int unsigned FRAME_LO = 60000,
    parameter int unsigned LINE_HI  = 1750,
    parameter int unsigned LINE_LO  = 420
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             frame_hi,
    output logic             frame_start,
    output logic             line_hi,
    output logic [VG_CW-1:0] col,
    output logic [VG_CW-1:0] row
);

    localparam int unsigned FRAME_P = FRAME_HI + FRAME_LO;
    localparam int unsigned LINE_P  = LINE_HI + LINE_LO;
    localparam int unsigned FCW     = $clog2(FRAME_P);
    localparam int unsigned LCW     = $clog2(LINE_P);

    logic [FCW-1:0]   fcnt;
    logic [LCW-1:0]   lcnt;
    logic [VG_CW-1:0] row_q;
    logic             line_wrap;

    // Frame position: low phase first, then high phase, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (fcnt == FCW'(FRAME_P - 1)) begin
            fcnt <= '0;
        end else begin
            fcnt <= fcnt + FCW'(1);
        end
    end

    // Phase decode of the frame position.
    always_comb begin
        frame_hi    = (fcnt >= FCW'(FRAME_LO));
        frame_start = (fcnt == FCW'(FRAME_LO - 1));
        line_wrap   = (lcnt == LCW'(LINE_P - 1));
    end

    // Position within the line; held at zero outside the frame-high phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_hi) begin
            lcnt <= '0;
        end else if (line_wrap) begin
            lcnt <= '0;
        end else begin
            lcnt <= lcnt + LCW'(1);
        end
    end

    // Line index within the frame, counted only during frame high.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_hi) begin
            row_q <= '0;
        end else if (line_wrap) begin
            row_q <= row_q + VG_CW'(1);
        end
    end

    // Line sync decode and coordinate outputs.
    always_comb begin
        line_hi = frame_hi && (lcnt < LCW'(LINE_HI));
        col     = VG_CW'(lcnt);
        row     = row_q;
    end

endmodule

// File: rtl/vg_params.sv
// Module: register shadowing and target motion.
// Writes land in a shadow copy; the live copy and the target column update
// together on frame_start so one frame always sees one consistent setting.
// Assumes frame_start is a single-cycle pulse once per frame.
module vg_params
    import vg_pkg::*;
#(
    parameter int unsigned LINE_HI = 1750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [VG_AW-1:0] cfg_addr,
    input  logic [VG_CW-1:0] cfg_wdata,
    input  logic             frame_start,
    output vg_cfg_t          live,
    output logic [VG_CW-1:0] tgt_x
);

    localparam int unsigned EW = VG_CW + 2;
    localparam vg_cfg_t CFG_RST = '{
        tgt_gray:  VG_GW'(255),
        bg_gray:   VG_GW'(0),
        size:      VG_CW'(16),
        speed:     VG_CW'(1),
        ypos:      VG_CW'(0),
        limit:     VG_CW'(LINE_HI),
        stream_bg: 1'b0
    };

    vg_cfg_t          shadow_q;
    vg_cfg_t          live_q;
    logic [VG_CW-1:0] x_q;
    logic             fwd_q;
    logic [VG_CW-1:0] x_nxt;
    logic             fwd_nxt;
    logic [EW-1:0]    step_x;
    logic [EW-1:0]    step_end;
    logic [VG_CW-1:0] room;

    // Shadow register writes by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= CFG_RST;
        end else if (cfg_we) begin
            case (vg_reg_e'(cfg_addr))
                REG_TGT_GRAY: shadow_q.tgt_gray  <= cfg_wdata[VG_GW-1:0];
                REG_BG_GRAY:  shadow_q.bg_gray   <= cfg_wdata[VG_GW-1:0];
                REG_SIZE:     shadow_q.size      <= cfg_wdata;
                REG_SPEED:    shadow_q.speed     <= cfg_wdata;
                REG_YPOS:     shadow_q.ypos      <= cfg_wdata;
                REG_LIMIT:    shadow_q.limit     <= cfg_wdata;
                REG_SRC:      shadow_q.stream_bg <= cfg_wdata[0];
                default:      ;
            endcase
        end
    end

    // Live copy follows the shadow only at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= CFG_RST;
        end else if (frame_start) begin
            live_q <= shadow_q;
        end
    end

    // Next column and direction with edge clamping, using the incoming settings.
    always_comb begin
        step_x   = EW'(x_q) + EW'(shadow_q.speed);
        step_end = step_x + EW'(shadow_q.size);
        room     = (shadow_q.size > shadow_q.limit) ? '0 : (shadow_q.limit - shadow_q.size);
        x_nxt    = x_q;
        fwd_nxt  = fwd_q;
        if (fwd_q) begin
            if (step_end > EW'(shadow_q.limit)) begin
                x_nxt   = room;
                fwd_nxt = 1'b0;
            end else begin
                x_nxt = step_x[VG_CW-1:0];
            end
        end else begin
            if (x_q < shadow_q.speed) begin
                x_nxt   = '0;
                fwd_nxt = 1'b1;
            end else begin
                x_nxt = x_q - shadow_q.speed;
            end
        end
    end

    // Target column register, advanced once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            fwd_q <= 1'b1;
        end else if (frame_start) begin
            x_q   <= x_nxt;
            fwd_q <= fwd_nxt;
        end
    end

    assign live  = live_q;
    assign tgt_x = x_q;

endmodule

// File: rtl/vg_compose.sv
// Module: per-pixel compositing and output registers.
// Stage 1 registers the decoded position (target hit, active, syncs) while a
// streamed background pixel is requested; stage 2 merges the pixel that
// arrived and drives the outputs. Assumes the stream answers one cycle late.
module vg_compose
    import vg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_hi,
    input  logic             line_hi,
    input  logic [VG_CW-1:0] col,
    input  logic [VG_CW-1:0] row,
    input  vg_cfg_t          live,
    input  logic [VG_CW-1:0] tgt_x,
    input  logic             bg_valid,
    input  logic [VG_GW-1:0] bg_pix,
    output logic             bg_req,
    output logic             vid_fsync,
    output logic             vid_lsync,
    output logic             vid_valid,
    output logic [VG_GW-1:0] vid_pix,
    output logic             underflow
);

    localparam int unsigned EW = VG_CW + 1;

    logic             act;
    logic             in_tgt;
    logic [EW-1:0]    x_end;
    logic [EW-1:0]    y_end;
    logic             s1_fs;
    logic             s1_ls;
    logic             s1_act;
    logic             s1_tgt;
    logic             s1_strm;
    logic [VG_GW-1:0] s1_tg;
    logic [VG_GW-1:0] s1_bg;
    logic             need_stream;

    // Window decode of the current position against the target square.
    always_comb begin
        x_end  = EW'(tgt_x) + EW'(live.size);
        y_end  = EW'(live.ypos) + EW'(live.size);
        act    = line_hi && (col < live.limit);
        in_tgt = (col >= tgt_x) && (EW'(col) < x_end) &&
                 (row >= live.ypos) && (EW'(row) < y_end);
        bg_req = act && live.stream_bg;
    end

    // Stage 1: capture position decode and the frame's gray levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_fs   <= 1'b0;
            s1_ls   <= 1'b0;
            s1_act  <= 1'b0;
            s1_tgt  <= 1'b0;
            s1_strm <= 1'b0;
            s1_tg   <= '0;
            s1_bg   <= '0;
        end else begin
            s1_fs   <= frame_hi;
            s1_ls   <= line_hi;
            s1_act  <= act;
            s1_tgt  <= in_tgt;
            s1_strm <= live.stream_bg;
            s1_tg   <= live.tgt_gray;
            s1_bg   <= live.bg_gray;
        end
    end

    // A requested stream pixel is being sampled this cycle.
    assign need_stream = s1_act && s1_strm;

    // Stage 2: select target, streamed or programmed gray and register outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_fsync <= 1'b0;
            vid_lsync <= 1'b0;
            vid_valid <= 1'b0;
            vid_pix   <= '0;
        end else begin
            vid_fsync <= s1_fs;
            vid_lsync <= s1_ls;
            vid_valid <= s1_act;
            if (s1_act && s1_tgt) begin
                vid_pix <= s1_tg;
            end else if (need_stream && bg_valid) begin
                vid_pix <= bg_pix;
            end else begin
                vid_pix <= s1_bg;
            end
        end
    end

    // Sticky late-stream flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (need_stream && !bg_valid) begin
            underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/vidgen_top.sv
// Module: moving-target test video generator top.
// Wires timing, register/motion and compositing stages. All outputs are
// registered; bg_req is decoded from counter state two cycles ahead of the
// pixel it serves. Assumes a single clock domain and a synchronous reset.
module vidgen_top
    import vg_pkg::*;
#(
    parameter int unsigned FRAME_HI = 1650000,
    parameter int unsigned FRAME_LO = 60000,
    parameter int unsigned LINE_HI  = 1750,
    parameter int unsigned LINE_LO  = 420
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [VG_AW-1:0] cfg_addr,
    input  logic [VG_CW-1:0] cfg_wdata,
    output logic             bg_req,
    input  logic             bg_valid,
    input  logic [VG_GW-1:0] bg_pix,
    output logic             vid_fsync,
    output logic             vid_lsync,
    output logic             vid_valid,
    output logic [VG_GW-1:0] vid_pix,
    output logic             underflow
);

    logic             frame_hi;
    logic             frame_start;
    logic             line_hi;
    logic [VG_CW-1:0] col;
    logic [VG_CW-1:0] row;
    vg_cfg_t          live;
    logic [VG_CW-1:0] tgt_x;

    vg_timing #(
        .FRAME_HI (FRAME_HI),
        .FRAME_LO (FRAME_LO),
        .LINE_HI  (LINE_HI),
        .LINE_LO  (LINE_LO)
    ) i_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_hi    (frame_hi),
        .frame_start (frame_start),
        .line_hi     (line_hi),
        .col         (col),
        .row         (row)
    );

    vg_params #(
        .LINE_HI (LINE_HI)
    ) i_params (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .live        (live),
        .tgt_x       (tgt_x)
    );

    vg_compose i_compose (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_hi  (frame_hi),
        .line_hi   (line_hi),
        .col       (col),
        .row       (row),
        .live      (live),
        .tgt_x     (tgt_x),
        .bg_valid  (bg_valid),
        .bg_pix    (bg_pix),
        .bg_req    (bg_req),
        .vid_fsync (vid_fsync),
        .vid_lsync (vid_lsync),
        .vid_valid (vid_valid),
        .vid_pix   (vid_pix),
        .underflow (underflow)
    );

endmodule

// File: rtl/vg_checker.sv
// Module: protocol checker for vidgen_top, attached by bind.
// Observes only top-level ports; relations are checked across cycles.
module vg_checker (
    input logic clk,
    input logic rst_n,
    input logic bg_req,
    input logic bg_valid,
    input logic vid_fsync,
    input logic vid_lsync,
    input logic vid_valid,
    input logic underflow
);

    // R2: no line activity outside the frame-high phase.
    p_line_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vid_lsync |-> vid_fsync);

    // R2: every frame-high phase opens with a line.
    p_frame_opens_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_fsync) |-> vid_lsync);

    // R3: valid pixels only inside a line.
    p_valid_in_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> vid_lsync);

    // R7: each request is followed two cycles later by a valid pixel.
    p_req_to_pixel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bg_req |-> ##2 vid_valid);

    // R8: the late-stream flag never clears on its own.
    p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R8: the flag rises only after a request that went unanswered.
    p_underflow_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> ($past(bg_req, 2) && !$past(bg_valid)));

endmodule

bind vidgen_top vg_checker i_vg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bg_req    (bg_req),
    .bg_valid  (bg_valid),
    .vid_fsync (vid_fsync),
    .vid_lsync (vid_lsync),
    .vid_valid (vid_valid),
    .underflow (underflow)
);

// File: tb/test_vidgen_top.sv
// Bench: behavioural per-cycle reference model plus directed scenario checks.
module test_vidgen_top;

    localparam int CLK_PERIOD = 20;
    localparam int FLO = 20;
    localparam int FHI = 300;
    localparam int LHI = 24;
    localparam int LLO = 6;
    localparam int FP  = FHI + FLO;
    localparam int LP  = LHI + LLO;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        bg_valid = 1'b0;
    logic [7:0]  bg_pix = '0;
    logic        bg_req;
    logic        vid_fsync;
    logic        vid_lsync;
    logic        vid_valid;
    logic [7:0]  vid_pix;
    logic        underflow;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_en = 0;
    bit gap_en = 0;
    bit prev_req = 0;
    logic [7:0] ramp = 8'd0;

    vidgen_top #(
        .FRAME_HI (FHI),
        .FRAME_LO (FLO),
        .LINE_HI  (LHI),
        .LINE_LO  (LLO)
    ) i_vidgen_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bg_req    (bg_req),
        .bg_valid  (bg_valid),
        .bg_pix    (bg_pix),
        .vid_fsync (vid_fsync),
        .vid_lsync (vid_lsync),
        .vid_valid (vid_valid),
        .vid_pix   (vid_pix),
        .underflow (underflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model (settings indexed by address) ----------
    int sh[7];
    int lv[7];
    int fp, mx;
    bit mfwd;
    bit s1_fs, s1_ls, s1_act, s1_tgt, s1_md;
    int s1_tg, s1_bg;
    bit e_fs, e_ls, e_val, e_uf, e_req;
    int e_pix;

    function automatic int rst_val(input int a);
        case (a)
            0: return 255;
            2: return 16;
            3: return 1;
            5: return LHI;
            default: return 0;
        endcase
    endfunction

    function automatic bit active_at(input int p);
        int lp;
        if (p < FLO) return 0;
        lp = (p - FLO) % LP;
        return (lp < LHI) && (lp < lv[5]);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            fp = 0; mx = 0; mfwd = 1;
            for (int i = 0; i < 7; i++) begin sh[i] = rst_val(i); lv[i] = rst_val(i); end
            s1_fs = 0; s1_ls = 0; s1_act = 0; s1_tgt = 0; s1_md = 0; s1_tg = 0; s1_bg = 0;
            e_fs = 0; e_ls = 0; e_val = 0; e_uf = 0; e_pix = 0; e_req = 0;
        end else begin
            int lp, rw;
            bit fhi, lhi;
            // output stage (R7, R8: stream sampled one cycle after request)
            e_fs = s1_fs; e_ls = s1_ls; e_val = s1_act;
            if (s1_act && s1_md && !bg_valid) e_uf = 1;
            if (s1_act && s1_tgt) e_pix = s1_tg;
            else if (s1_act && s1_md && bg_valid) e_pix = bg_pix;
            else e_pix = s1_bg;
            // position of this cycle (R1, R2, R3, R4)
            fhi = (fp >= FLO);
            lp = fhi ? (fp - FLO) % LP : 0;
            rw = fhi ? (fp - FLO) / LP : 0;
            lhi = fhi && (lp < LHI);
            s1_fs = fhi; s1_ls = lhi;
            s1_act = lhi && (lp < lv[5]);
            s1_tgt = (lp >= mx) && (lp < mx + lv[2]) && (rw >= lv[4]) && (rw < lv[4] + lv[2]);
            s1_md = lv[6][0]; s1_tg = lv[0]; s1_bg = lv[1];
            // frame boundary: settings apply and target moves (R5, R6)
            if (fp == FLO - 1) begin
                for (int i = 0; i < 7; i++) lv[i] = sh[i];
                if (mfwd) begin
                    if (mx + sh[3] + sh[2] > sh[5]) begin
                        mx = (sh[2] > sh[5]) ? 0 : sh[5] - sh[2];
                        mfwd = 0;
                    end else mx = mx + sh[3];
                end else begin
                    if (mx < sh[3]) begin mx = 0; mfwd = 1; end
                    else mx = mx - sh[3];
                end
            end
            if (cfg_we && cfg_addr < 7) begin
                if (cfg_addr < 2) sh[cfg_addr] = cfg_wdata & 255;
                else if (cfg_addr == 6) sh[cfg_addr] = cfg_wdata & 1;
                else sh[cfg_addr] = int'(cfg_wdata);
            end
            fp = (fp + 1) % FP;
            e_req = active_at(fp) && lv[6][0];
        end
    end

    // Compare every cycle at negedge, then drive the stream responder.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(vid_fsync == e_fs, "R1 fsync", vid_fsync, e_fs);
            chk(vid_lsync == e_ls, "R2 lsync", vid_lsync, e_ls);
            chk(vid_valid == e_val, "R3 valid", vid_valid, e_val);
            chk(vid_pix == e_pix[7:0], "R4 R6 R7 pixel", vid_pix, e_pix);
            chk(bg_req == e_req, "R7 request", bg_req, e_req);
            chk(underflow == e_uf, "R8 underflow", underflow, e_uf);
        end
        ramp = ramp + 8'd1;
        bg_pix = ramp;
        bg_valid = prev_req && !(gap_en && ramp[2:0] == 3'd5);
        prev_req = bg_req;
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 12'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Leaves the caller at the negedge of the first frame-high output cycle.
    task automatic to_frame_rise();
        do @(negedge clk); while (vid_fsync);
        do @(negedge clk); while (!vid_fsync);
    endtask

    initial begin
        int n, m, v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cmp_en = 1;
        // R9: reset state at the ports
        chk(vid_fsync == 0 && vid_lsync == 0 && vid_valid == 0, "R9 syncs in reset", vid_fsync, 0);
        chk(vid_pix == 0, "R9 pixel in reset", vid_pix, 0);
        chk(underflow == 0 && bg_req == 0, "R9 flags in reset", underflow, 0);
        rst_n = 1'b1;

        // R9: reset gray levels visible in the first frame (target 255 at row 0)
        to_frame_rise();
        n = 0;
        do begin if (vid_valid && vid_pix == 8'd255) n++; @(negedge clk); end while (vid_fsync);
        chk(n == 16 * 10, "R9 reset target rows", n, 160);

        wr(0, 8'hC8); wr(1, 8'h10); wr(2, 4); wr(3, 7); wr(4, 2); wr(5, 20);
        wr(7, 12'hFFF);  // R5: unused address, must not disturb output

        // R1 / R2 / R3: measure one frame's timing and the active width
        to_frame_rise();
        n = 1; m = 1; v = vid_valid ? 1 : 0;
        forever begin
            @(negedge clk);
            if (!vid_lsync) break;
            m++; if (vid_valid) v++;
        end
        chk(m == LHI, "R2 line high length", m, LHI);
        chk(v == 20, "R3 valid per line", v, 20);
        m = 0;
        while (!vid_lsync) begin m++; @(negedge clk); end
        chk(m == LLO, "R2 line low length", m, LLO);
        n = LP + 1;
        forever begin @(negedge clk); if (!vid_fsync) break; n++; end
        chk(n == FHI, "R1 frame high length", n, FHI);
        m = 0;
        while (!vid_fsync) begin m++; @(negedge clk); end
        chk(m == FLO, "R1 frame low length", m, FLO);

        // R4: a whole frame shows exactly size*size target pixels
        n = 0;
        do begin if (vid_valid && vid_pix == 8'hC8) n++; @(negedge clk); end while (vid_fsync);
        chk(n == 16, "R4 target pixel count", n, 16);

        // R5: mid-frame gray write is held back until the next frame
        to_frame_rise();
        repeat (60) @(negedge clk);
        wr(0, 8'h55);
        n = 0;
        do begin if (vid_pix == 8'h55) n++; @(negedge clk); end while (vid_fsync);
        chk(n == 0, "R5 no new gray in current frame", n, 0);
        to_frame_rise();
        n = 0;
        do begin if (vid_valid && vid_pix == 8'h55) n++; @(negedge clk); end while (vid_fsync);
        chk(n == 16, "R5 new gray next frame", n, 16);

        // R6: run enough frames for bounces at both edges (model compares each cycle)
        repeat (8) to_frame_rise();
        wr(3, 2);
        repeat (4) to_frame_rise();

        // R7: streamed background, every request answered
        wr(6, 1);
        to_frame_rise();
        to_frame_rise();
        n = 0;
        do begin if (bg_req) n++; @(negedge clk); end while (vid_fsync);
        while (!vid_fsync) begin if (bg_req) n++; @(negedge clk); end
        chk(n == 200, "R7 requests per frame", n, 200);
        repeat (2) to_frame_rise();
        chk(underflow == 0, "R8 no underflow with prompt stream", underflow, 0);

        // R8: dropped answers fall back and set the sticky flag
        gap_en = 1;
        repeat (2) to_frame_rise();
        gap_en = 0;
        to_frame_rise();
        chk(underflow == 1, "R8 sticky after late stream", underflow, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule